// File: doc/BRIEF.md
# Polled Bus Request Retry Controller

This block sequences one master-side transaction on a half-duplex polled bus. A host hands it a target slave address and a request kind: information query, heartbeat or command. The block asks the packet framer to transmit. Once the framer reports that the last bit has left the line, the block opens a reply window of a fixed number of clock cycles. During that window it watches the parser's reply indications for a good reply from the addressed station.

If the window closes with no such reply, the request is sent again, up to a fixed number of resends. If a reply arrives in time, the transaction ends with success. If every attempt runs out, the slave is reported as down. Success means something different for each kind (information received, slave alive, command taken), so the kind is returned with the result. The block does not build or parse packets.

The request port and the send port follow valid/ready rules. The request port accepts only while idle, and anything offered during a transaction is dropped. The send port holds its request steady until the framer takes it. Reply indications and the end-of-transmission pulse are plain single-cycle inputs with no back-pressure.

Top module: `master_retry_ctrl`

## Requirements
- R1: While reset is active and just after it, req_ready is 1, send_valid is 0, done is 0, status is 0 (idle: no result yet) and attempts is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From then until the result, req_ready is 0 and status is 1 (busy). A req_valid offered while busy is ignored and does not change the address or kind sent.
- R3: For each attempt, send_valid rises carrying the latched target on send_addr and the kind on send_kind (0 info, 1 heartbeat, 2 command). While send_ready is 0, send_valid and both fields hold unchanged.
- R4: The reply window starts at the end of transmission, not at the send handshake. It is TIMEOUT_CYC cycles long, and its first cycle follows the edge that samples tx_done. A qualifying reply sampled in any of those cycles counts, including the last one.
- R5: When the window closes with no qualifying reply and resends remain, send_valid is high again TIMEOUT_CYC edges after the tx_done edge, and attempts has grown by one.
- R6: When the window of attempt MAX_RESENDS+1 closes with no reply, done pulses with status 3 (slave down) and attempts equal to MAX_RESENDS+1.
- R7: A qualifying reply sampled at edge k of a window raises done right after that same edge. It comes with status 2 (success), attempts equal to the current attempt number, and done_kind equal to the request kind.
- R8: A reply whose rsp_addr differs from the target is ignored, even when it is flagged good.
- R9: A reply from the target with rsp_good at 0 is ignored and does not stop the window timer.
- R10: A reply sampled outside a window is ignored. This covers a reply before tx_done, and one that arrives after a window closes while the resend is pending.
- R11: done lasts exactly one cycle. Status and attempts then hold their final values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Target slave address |
| req_kind | input | 2 | Request kind: 0 info, 1 heartbeat, 2 command |
| send_valid | output | 1 | Asks the framer to transmit a packet |
| send_ready | input | 1 | Framer takes the send request |
| send_addr | output | ADDR_W | Address to put in the packet |
| send_kind | output | 2 | Kind to put in the packet |
| tx_done | input | 1 | One-cycle pulse: the packet has left the line |
| rsp_valid | input | 1 | One-cycle pulse: the parser has a reply |
| rsp_addr | input | ADDR_W | Source address of the reply |
| rsp_good | input | 1 | Reply passed CRC and framing checks |
| done | output | 1 | One-cycle pulse: transaction finished |
| status | output | 2 | 0 idle, 1 busy, 2 success, 3 slave down |
| attempts | output | $clog2(MAX_RESENDS+2) | Transmissions used in this transaction |
| done_kind | output | 2 | Kind of the finished request |

## Verification
Every result is due on a fixed edge. A retransmit request shows TIMEOUT_CYC edges after the edge that samples tx_done. A good, matching reply sampled at edge k produces done just after edge k. A request is reported busy one edge after it is taken. The bench drives each input just after a rising edge and reads the outputs at the following falling edge. It counts rising edges from the tx_done edge and checks that count for both the resend and the completion. Misleading replies are placed on exact edges inside and outside the window, so that any wrongly counted reply would move the completion edge.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BUSY    = 2'd1,
    ST_SUCCESS = 2'd2,
    ST_DOWN    = 2'd3
  } mrc_status_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SEND   = 2'd1,
    PH_TXWAIT = 2'd2,
    PH_LISTEN = 2'd3
  } mrc_phase_e;
endpackage

// File: rtl/mrc_timer.sv
module mrc_timer #(
  parameter int TIMEOUT_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (start)                  cnt <= '0;
    else if (run && cnt != LAST)     cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

  // R4: the count never passes the last cycle of the window
  a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/mrc_reply_match.sv
module mrc_reply_match #(
  parameter int ADDR_W = 8
) (
  input  logic              listen,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              rsp_good,
  input  logic [ADDR_W-1:0] target,
  output logic              hit
);
  // R8, R9, R10: only a good reply from the target inside a window qualifies
  always_comb begin
    hit = listen && rsp_valid && rsp_good && (rsp_addr == target);
  end
endmodule

// File: rtl/mrc_seq.sv
module mrc_seq
  import mrc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int MAX_RESENDS = 3,
  parameter int CNT_W       = $clog2(MAX_RESENDS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              send_valid,
  input  logic              send_ready,
  input  logic              tx_done,
  input  logic              hit,
  input  logic              expire,
  output logic              timer_start,
  output logic              listen,
  output logic [ADDR_W-1:0] target,
  output logic [1:0]        kind,
  output logic              done,
  output logic [1:0]        status,
  output logic [CNT_W-1:0]  att
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RESENDS + 1);

  mrc_phase_e  phase;
  mrc_status_e st;

  assign req_ready   = (phase == PH_IDLE);
  assign send_valid  = (phase == PH_SEND);
  assign listen      = (phase == PH_LISTEN);
  assign timer_start = (phase == PH_TXWAIT) && tx_done;
  assign status      = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      st     <= ST_IDLE;
      target <= '0;
      kind   <= '0;
      att    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          target <= req_addr;
          kind   <= req_kind;
          att    <= CNT_W'(1);
          st     <= ST_BUSY;
          phase  <= PH_SEND;
        end
        PH_SEND:   if (send_ready) phase <= PH_TXWAIT;
        PH_TXWAIT: if (tx_done)    phase <= PH_LISTEN;
        PH_LISTEN: begin
          if (hit) begin
            st    <= ST_SUCCESS;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else if (expire) begin
            if (att == LIMIT) begin
              st    <= ST_DOWN;
              done  <= 1'b1;
              phase <= PH_IDLE;
            end else begin
              att   <= att + 1'b1;
              phase <= PH_SEND;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: a pending send request is held steady under back-pressure
  a_r3_send_hold: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid && !send_ready |=> send_valid && $stable(target) && $stable(kind));

  // R2: no new request is taken while a transaction is busy
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BUSY |-> !req_ready);

  // R7: a qualifying reply in the window completes with success
  a_r7_hit_success: assert property (@(posedge clk) disable iff (!rst_n)
    listen && hit |=> done && st == ST_SUCCESS);

  // R6: slave-down is reported only after the full attempt budget
  a_r6_down_full: assert property (@(posedge clk) disable iff (!rst_n)
    done && st == ST_DOWN |-> att == LIMIT);

  // R5: attempt count never exceeds the budget
  a_r5_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    att <= LIMIT);

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/master_retry_ctrl.sv
module master_retry_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int TIMEOUT_CYC = 5_000_000,
  parameter int MAX_RESENDS = 3,
  parameter int CNT_W       = $clog2(MAX_RESENDS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              send_valid,
  input  logic              send_ready,
  output logic [ADDR_W-1:0] send_addr,
  output logic [1:0]        send_kind,
  input  logic              tx_done,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              rsp_good,
  output logic              done,
  output logic [1:0]        status,
  output logic [CNT_W-1:0]  attempts,
  output logic [1:0]        done_kind
);
  logic              hit, expire, timer_start, listen;
  logic [ADDR_W-1:0] target;
  logic [1:0]        kind;

  mrc_seq #(.ADDR_W(ADDR_W), .MAX_RESENDS(MAX_RESENDS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind),
    .send_valid(send_valid), .send_ready(send_ready),
    .tx_done(tx_done), .hit(hit), .expire(expire),
    .timer_start(timer_start), .listen(listen),
    .target(target), .kind(kind),
    .done(done), .status(status), .att(attempts)
  );

  mrc_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(timer_start), .run(listen), .expire(expire)
  );

  mrc_reply_match #(.ADDR_W(ADDR_W)) u_match (
    .listen(listen), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_good(rsp_good), .target(target), .hit(hit)
  );

  assign send_addr = target;
  assign send_kind = kind;
  assign done_kind = kind;
endmodule

// File: tb/master_retry_ctrl_bench.sv
module master_retry_ctrl_bench;
  localparam int AW    = 8;
  localparam int T     = 20;
  localparam int MAXR  = 3;
  localparam int CW    = $clog2(MAXR + 2);

  typedef struct packed {
    logic [1:0]    st;
    logic [CW-1:0] att;
    logic [1:0]    kind;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, send_ready = 0, tx_done = 0, rsp_valid = 0, rsp_good = 0;
  logic [AW-1:0] req_addr = '0, rsp_addr = '0;
  logic [1:0] req_kind = '0;
  logic req_ready, send_valid, done;
  logic [AW-1:0] send_addr;
  logic [1:0] send_kind, status, done_kind;
  logic [CW-1:0] attempts;

  int n_chk = 0, n_fail = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  master_retry_ctrl #(.ADDR_W(AW), .TIMEOUT_CYC(T), .MAX_RESENDS(MAXR)) u_master_retry_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
    .send_valid(send_valid), .send_ready(send_ready), .send_addr(send_addr), .send_kind(send_kind),
    .tx_done(tx_done), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_good(rsp_good),
    .done(done), .status(status), .attempts(attempts), .done_kind(done_kind)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic drv_rsp(input logic [AW-1:0] a, input logic good);
    rsp_valid = 1; rsp_addr = a; rsp_good = good;
  endtask

  // Monitor: pops expected results as done appears
  logic prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(!done, "R11 done single cycle", done, 0);
      if (done) begin
        if (sb.size() == 0) chk(0, "R7 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(status == e.st, "R6/R7 final status", status, e.st);
          chk(attempts == e.att, "R6/R7 attempts used", attempts, e.att);
          chk(done_kind == e.kind, "R7 done_kind", done_kind, e.kind);
        end
      end
      prev_done = done;
    end
  end

  task automatic run_txn(input logic [AW-1:0] a, input logic [1:0] k, input int reply_at,
                         input int dly, input bit junk, input bit late, input bit early,
                         input bit poke);
    exp_t e;
    int exp_att;
    logic [1:0] exp_st;
    exp_att = (reply_at == 0) ? MAXR + 1 : reply_at;
    exp_st  = (reply_at == 0) ? 2'd3 : 2'd2;
    e.st = exp_st; e.att = CW'(exp_att); e.kind = k;
    sb.push_back(e);

    @(posedge clk); #1 req_valid = 1; req_addr = a; req_kind = k;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(req_ready == 0, "R2 ready low while busy", req_ready, 0);
    chk(status == 2'd1, "R2 status busy", status, 1);
    if (poke) begin
      req_valid = 1; req_addr = a ^ 8'hFF; req_kind = ~k;
      @(posedge clk); #1 req_valid = 0;
    end

    for (int n = 1; n <= MAXR + 1; n++) begin
      int ecnt;
      bit stop;
      forever begin
        @(negedge clk);
        if (send_valid) break;
      end
      chk(send_addr == a, "R3 send_addr (R2 poke ignored)", send_addr, a);
      chk(send_kind == k, "R3 send_kind", send_kind, k);
      chk(attempts == CW'(n), "R5 attempt number", attempts, n);
      @(posedge clk); @(negedge clk);
      chk(send_valid && send_addr == a, "R3 held under back-pressure", send_valid, 1);
      send_ready = 1;
      @(posedge clk); #1 send_ready = 0;
      for (int w = 0; w < 5; w++) begin
        if (early && n == 1 && w == 2) drv_rsp(a, 1'b1);  // R10: before tx_done
        @(posedge clk); #1 rsp_valid = 0;
      end
      tx_done = 1;
      @(posedge clk); #1 tx_done = 0;
      stop = 0; ecnt = 0;
      for (int c = 1; c <= T + 2 && !stop; c++) begin
        if (n == reply_at && c == dly) drv_rsp(a, 1'b1);
        else if (junk && c == 2) drv_rsp(a ^ 8'h01, 1'b1);  // R8
        else if (junk && c == 3) drv_rsp(a, 1'b0);          // R9
        @(posedge clk); #1 rsp_valid = 0;
        @(negedge clk);
        if (send_valid || done) begin stop = 1; ecnt = c; end
      end
      if (n == reply_at) begin
        chk(ecnt == dly && done, "R7 done edge after reply (R4 window)", ecnt, dly);
        break;
      end
      chk(ecnt == T, "R4/R9 window length from tx_done", ecnt, T);
      if (n <= MAXR) chk(send_valid, "R5 resend after timeout", send_valid, 1);
      else           chk(done && status == 2'd3, "R6 slave down", status, 3);
      if (late && n <= MAXR) begin
        drv_rsp(a, 1'b1);  // R10: after window closed
        @(posedge clk); #1 rsp_valid = 0;
      end
    end
    repeat (3) @(negedge clk);
    chk(status == exp_st, "R11 status holds", status, exp_st);
    chk(attempts == CW'(exp_att), "R11 attempts hold", attempts, exp_att);
    chk(req_ready == 1, "R2 ready after finish", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1 && send_valid == 0, "R1 reset handshakes", send_valid, 0);
    chk(done == 0 && status == 2'd0 && attempts == 0, "R1 reset status", status, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && status == 2'd0, "R1 idle after reset", status, 0);

    run_txn(8'd5,   2'd0, 1, 4,     0, 0, 0, 1);  // R7 quick info reply, R2 poke
    run_txn(8'd12,  2'd1, 0, 0,     0, 0, 0, 0);  // R6 heartbeat down
    run_txn(8'd7,   2'd2, 2, T,     1, 0, 0, 0);  // R4 last-cycle reply, R8 R9 junk
    run_txn(8'd3,   2'd0, 0, 0,     1, 1, 1, 0);  // R10 early and late replies
    run_txn(8'd200, 2'd2, 4, 1,     0, 0, 0, 0);  // R7 reply on final attempt
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7 all results seen", sb.size(), 0);
    summary();
    $finish;
  end
endmodule